// File: doc/BRIEF.md
# Write-Combining Store Buffer

This block sits between a core's store stream and the memory bus for one write-combining address region. It keeps a single line of `LINE_BYTES` bytes (32 by default), aligned to its own size, with one valid bit per byte. Byte, halfword and doubleword stores that land in the held line are merged into it without any bus traffic, so a stream of small sequential stores reaches memory as far fewer, larger transfers.

Once every byte of the line is valid, the block issues the whole line as one burst. When it must give the line up before it is complete, it drains the valid bytes as a series of doubleword writes with byte enables, lowest address first. A drain is forced by a store to another line, an uncached access, an I/O access, a write-combining load that misses the held line, or a serialising event pulse. While a drain is under way, new stores are held off with `st_ready`.

Top module: `wc_buffer`

## Requirements
- R1: A store (32-bit `st_data`, 4-bit `st_be` for bytes 0..3 of the doubleword, `st_addr[4:2]` selecting the doubleword in the line, `st_addr[1:0]` ignored) to the held line, or to an empty buffer, is merged into the line and produces no bus write by itself unless it completes the line.
- R2: A store to a byte that is already valid overwrites that byte in place; no flush occurs and the later value is the one written out.
- R3: When all 32 bytes are valid the line is written as one burst: `bus_burst`=1, `bus_addr` is the line base with bits [4:0] zero, byte i of the line on `bus_data[8i+7:8i]`, `bus_be`=4'hF.
- R4: A flush of a partly filled line issues one write per doubleword that holds a valid byte, in ascending address order: `bus_burst`=0, `bus_addr` is the doubleword address, `bus_data[31:0]` carries the valid bytes with invalid bytes and bits above 31 zero, and `bus_be` marks the valid bytes.
- R5: A store to a different line while the buffer holds valid bytes is held with `st_ready`=0, the line is flushed, and the store is then accepted as the first data of the new line.
- R6: `acc_class` codes: 0 cached access, no effect; 1 uncached access, flush; 2 I/O access, flush; 3 write-combining load, flush only when `acc_addr` lies outside the held line, no effect when it lies inside.
- R7: A pulse on `ser_evt` flushes a non-empty buffer.
- R8: `st_ready` is 0 while a bus write is pending, and a pending bus write keeps its burst flag, address, data and enables until `bus_ready` accepts it.
- R9: After reset the buffer is empty, `bus_valid` is 0 and `st_ready` is 1.
- R10: A flush trigger on an empty buffer produces no bus write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Store accepted this cycle when high with st_valid |
| st_addr | input | ADDR_W | Store byte address |
| st_data | input | 32 | Store data, byte lane i on bits 8i+7:8i |
| st_be | input | 4 | Store byte enables |
| acc_valid | input | 1 | Other memory access observed this cycle |
| acc_class | input | 2 | Access class code (see R6) |
| acc_addr | input | ADDR_W | Address of the observed access |
| ser_evt | input | 1 | Serialising event pulse (interrupt, context switch, locked operation) |
| bus_valid | output | 1 | Bus write pending |
| bus_ready | input | 1 | Bus accepts the pending write |
| bus_burst | output | 1 | 1 for a whole-line burst, 0 for a doubleword write |
| bus_addr | output | ADDR_W | Write address |
| bus_data | output | 8*LINE_BYTES | Write data |
| bus_be | output | 4 | Byte enables of a doubleword write, all ones for a burst |

## Verification
The hardest situation to reach from the ports is a store that misses the held line while a partly filled line is still waiting: the bench must observe `st_ready` held low, then see the old line drain doubleword by doubleword, possibly stretched by a stalled `bus_ready`, before the new store is taken. Random stimulus confines addresses to three lines with random byte enables and random bus stalls, so misses, in-place overwrites and complete lines arise often. Directed sequences add a full fill, each access class, and triggers on an empty buffer. Every bus write is compared against a bench model of the line contents.

// File: rtl/wc_pkg.sv
package wc_pkg;
   typedef enum logic [1:0] {
      ACC_CACHED   = 2'd0,
      ACC_UNCACHED = 2'd1,
      ACC_IO       = 2'd2,
      ACC_WCLOAD   = 2'd3
   } acc_class_e;

   typedef enum logic {
      ST_IDLE  = 1'b0,
      ST_DRAIN = 1'b1
   } wc_state_e;
endpackage

// File: rtl/wc_line_store.sv
module wc_line_store #(
   parameter int LINE_BYTES = 32,
   parameter int WORD_BYTES = 4,
   localparam int NWORDS    = LINE_BYTES / WORD_BYTES,
   localparam int WIDX_W    = $clog2(NWORDS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [WIDX_W-1:0]           wr_idx,
   input  logic [WORD_BYTES-1:0]       wr_be,
   input  logic [WORD_BYTES*8-1:0]     wr_data,
   input  logic                        clr_all,
   input  logic                        clr_en,
   input  logic [WIDX_W-1:0]           clr_idx,
   output logic [LINE_BYTES-1:0]       valid_o,
   output logic [LINE_BYTES*8-1:0]     data_o
);
   for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
      localparam int WRD  = b / WORD_BYTES;
      localparam int LANE = b % WORD_BYTES;
      logic hit_wr, hit_clr;
      assign hit_wr  = wr_en && (wr_idx == WIDX_W'(WRD)) && wr_be[LANE];
      assign hit_clr = clr_all || (clr_en && (clr_idx == WIDX_W'(WRD)));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       valid_o[b] <= 1'b0;
         else if (hit_clr) valid_o[b] <= 1'b0;
         else if (hit_wr)  valid_o[b] <= 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      data_o[b*8 +: 8] <= '0;
         else if (hit_wr) data_o[b*8 +: 8] <= wr_data[LANE*8 +: 8];
      end
   end
endmodule

// File: rtl/wc_word_pick.sv
module wc_word_pick #(
   parameter int LINE_BYTES = 32,
   parameter int WORD_BYTES = 4,
   localparam int NWORDS    = LINE_BYTES / WORD_BYTES,
   localparam int WIDX_W    = $clog2(NWORDS),
   localparam int WBITS     = WORD_BYTES * 8
) (
   input  logic [LINE_BYTES-1:0]   valid_i,
   input  logic [LINE_BYTES*8-1:0] data_i,
   output logic [WIDX_W-1:0]       idx_o,
   output logic [WORD_BYTES-1:0]   be_o,
   output logic [WBITS-1:0]        word_o
);
   logic [WBITS-1:0] raw;

   always_comb begin
      idx_o = '0;
      for (int w = NWORDS - 1; w >= 0; w--) begin
         if (|valid_i[w*WORD_BYTES +: WORD_BYTES]) idx_o = WIDX_W'(w);
      end
   end

   assign be_o = valid_i[idx_o*WORD_BYTES +: WORD_BYTES];
   assign raw  = data_i[idx_o*WBITS +: WBITS];

   for (genvar l = 0; l < WORD_BYTES; l++) begin : g_lane
      assign word_o[l*8 +: 8] = be_o[l] ? raw[l*8 +: 8] : 8'h00;
   end
endmodule

// File: rtl/wc_buffer.sv
module wc_buffer
   import wc_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 32,
   parameter int WORD_BYTES = 4,
   localparam int NWORDS    = LINE_BYTES / WORD_BYTES,
   localparam int OFF_W     = $clog2(LINE_BYTES),
   localparam int WOFF_W    = $clog2(WORD_BYTES),
   localparam int WIDX_W    = $clog2(NWORDS),
   localparam int TAG_W     = ADDR_W - OFF_W,
   localparam int WBITS     = WORD_BYTES * 8,
   localparam int LINE_BITS = LINE_BYTES * 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  st_valid,
   output logic                  st_ready,
   input  logic [ADDR_W-1:0]     st_addr,
   input  logic [WBITS-1:0]      st_data,
   input  logic [WORD_BYTES-1:0] st_be,
   input  logic                  acc_valid,
   input  logic [1:0]            acc_class,
   input  logic [ADDR_W-1:0]     acc_addr,
   input  logic                  ser_evt,
   output logic                  bus_valid,
   input  logic                  bus_ready,
   output logic                  bus_burst,
   output logic [ADDR_W-1:0]     bus_addr,
   output logic [LINE_BITS-1:0]  bus_data,
   output logic [WORD_BYTES-1:0] bus_be
);
   if ((LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
      $error("LINE_BYTES must be a power of two");
   end
   if ((WORD_BYTES & (WORD_BYTES - 1)) != 0 || WORD_BYTES >= LINE_BYTES) begin : g_bad_word
      $error("WORD_BYTES must be a power of two below LINE_BYTES");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("ADDR_W too small for the line size");
   end

   wc_state_e             state_q;
   logic [TAG_W-1:0]      tag_q;
   logic [LINE_BYTES-1:0] valid_q;
   logic [LINE_BITS-1:0]  data_q;
   logic [LINE_BYTES-1:0] st_mask;
   logic [WIDX_W-1:0]     st_idx, pick_idx;
   logic [WORD_BYTES-1:0] pick_be;
   logic [WBITS-1:0]      pick_word;
   logic empty, full, st_hit, st_fire, bus_fire, flush_evt, load_miss, go_drain;
   acc_class_e            acc_kind;
   logic                  unused_addr_bits;

   assign unused_addr_bits = ^{acc_addr[OFF_W-1:0], st_addr[OFF_W-1:WOFF_W] & '0, st_addr[WOFF_W-1:0]};

   assign acc_kind  = acc_class_e'(acc_class);
   assign st_idx    = st_addr[OFF_W-1:WOFF_W];
   assign empty     = ~|valid_q;
   assign full      = &valid_q;
   assign st_hit    = (st_addr[ADDR_W-1:OFF_W] == tag_q);
   assign load_miss = (acc_addr[ADDR_W-1:OFF_W] != tag_q);

   always_comb begin
      flush_evt = ser_evt;
      if (acc_valid) begin
         unique case (acc_kind)
            ACC_UNCACHED, ACC_IO: flush_evt = 1'b1;
            ACC_WCLOAD:           flush_evt = flush_evt | load_miss;
            default:              ;
         endcase
      end
   end

   always_comb begin
      st_mask = '0;
      st_mask[st_idx*WORD_BYTES +: WORD_BYTES] = st_be;
   end

   assign st_ready = (state_q == ST_IDLE) && (empty || (st_hit && !flush_evt));
   assign st_fire  = st_valid && st_ready;
   assign go_drain = (st_fire && (&(valid_q | st_mask)))
                   || (!empty && (flush_evt || (st_valid && !st_hit)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
      end else begin
         unique case (state_q)
            ST_IDLE:  if (go_drain) state_q <= ST_DRAIN;
            ST_DRAIN: if (empty)    state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 tag_q <= '0;
      else if (st_fire && empty)  tag_q <= st_addr[ADDR_W-1:OFF_W];
   end

   wc_line_store #(.LINE_BYTES(LINE_BYTES), .WORD_BYTES(WORD_BYTES)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (st_fire),
      .wr_idx  (st_idx),
      .wr_be   (st_be),
      .wr_data (st_data),
      .clr_all (bus_fire && full),
      .clr_en  (bus_fire && !full),
      .clr_idx (pick_idx),
      .valid_o (valid_q),
      .data_o  (data_q)
   );

   wc_word_pick #(.LINE_BYTES(LINE_BYTES), .WORD_BYTES(WORD_BYTES)) u_pick (
      .valid_i (valid_q),
      .data_i  (data_q),
      .idx_o   (pick_idx),
      .be_o    (pick_be),
      .word_o  (pick_word)
   );

   assign bus_valid = (state_q == ST_DRAIN) && !empty;
   assign bus_fire  = bus_valid && bus_ready;
   assign bus_burst = full;
   assign bus_addr  = full ? {tag_q, {OFF_W{1'b0}}}
                           : {tag_q, pick_idx, {WOFF_W{1'b0}}};
   assign bus_data  = full ? data_q : LINE_BITS'(pick_word);
   assign bus_be    = full ? {WORD_BYTES{1'b1}} : pick_be;
endmodule

// File: rtl/wc_buffer_chk.sv
module wc_buffer_chk #(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 32,
   parameter int WORD_BYTES = 4,
   localparam int OFF_W     = $clog2(LINE_BYTES),
   localparam int WOFF_W    = $clog2(WORD_BYTES)
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    st_valid,
   input logic                    st_ready,
   input logic                    acc_valid,
   input logic [1:0]              acc_class,
   input logic                    ser_evt,
   input logic                    bus_valid,
   input logic                    bus_ready,
   input logic                    bus_burst,
   input logic [ADDR_W-1:0]       bus_addr,
   input logic [LINE_BYTES*8-1:0] bus_data,
   input logic [WORD_BYTES-1:0]   bus_be
);
   p_bus_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && !bus_ready |=> bus_valid && $stable(bus_burst) && $stable(bus_addr)
                                  && $stable(bus_data) && $stable(bus_be));

   p_store_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> !st_ready);

   p_burst_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && bus_burst |-> (bus_addr[OFF_W-1:0] == '0) && (&bus_be));

   p_part_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && !bus_burst |-> (bus_be != '0) && (bus_addr[WOFF_W-1:0] == '0));

   p_part_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && bus_ready && !bus_burst |=> !bus_valid
         || (!bus_burst && (bus_addr > $past(bus_addr))
             && (bus_addr[ADDR_W-1:OFF_W] == $past(bus_addr[ADDR_W-1:OFF_W]))));

   p_cached_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_valid && !st_valid && !ser_evt && (!acc_valid || acc_class == 2'd0) |=> !bus_valid);
endmodule

bind wc_buffer wc_buffer_chk #(
   .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .WORD_BYTES(WORD_BYTES)
) u_chk (.*);

// File: tb/wc_buffer_tb.sv
module wc_buffer_tb;
   typedef struct packed {
      logic         burst;
      logic [31:0]  addr;
      logic [255:0] data;
      logic [3:0]   be;
   } tr_t;

   logic clk = 1'b0, rst_n = 1'b0;
   logic st_valid = 1'b0, st_ready;
   logic [31:0] st_addr = '0, st_data = '0;
   logic [3:0]  st_be = '0;
   logic acc_valid = 1'b0;
   logic [1:0] acc_class = '0;
   logic [31:0] acc_addr = '0;
   logic ser_evt = 1'b0;
   logic bus_valid, bus_ready = 1'b0, bus_burst;
   logic [31:0] bus_addr;
   logic [255:0] bus_data;
   logic [3:0] bus_be;

   int checks = 0, errors = 0, cyc = 0;
   bit rdy_force_low = 1'b0;
   tr_t exp_q[$];
   logic [255:0] mb;
   logic [31:0]  mv;
   logic [26:0]  mtag;
   bit    held;
   tr_t   held_tr;

   always #10 clk = ~clk;

   wc_buffer u_dut (.*);

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         chk(1'b0, "R8", "watchdog expired", cyc, 150000);
         finish_run();
      end
   end

   always @(posedge clk) begin
      #2;
      bus_ready = rdy_force_low ? 1'b0 : (($urandom % 4) != 0);
   end

   // bench model of the held line
   task automatic model_flush;
      tr_t t;
      if (mv == '0) return;
      if (&mv) begin
         t.burst = 1'b1; t.addr = {mtag, 5'b0}; t.data = mb; t.be = 4'hF;
         exp_q.push_back(t);
      end else begin
         for (int w = 0; w < 8; w++) begin
            if (|mv[w*4 +: 4]) begin
               t.burst = 1'b0;
               t.addr  = {mtag, 3'(w), 2'b0};
               t.data  = '0;
               for (int l = 0; l < 4; l++)
                  if (mv[w*4+l]) t.data[l*8 +: 8] = mb[(w*4+l)*8 +: 8];
               t.be = mv[w*4 +: 4];
               exp_q.push_back(t);
            end
         end
      end
      mv = '0;
   endtask

   task automatic model_store(input logic [31:0] a, input logic [3:0] be, input logic [31:0] d);
      int w;
      if (mv == '0) mtag = a[31:5];
      w = int'(a[4:2]);
      for (int l = 0; l < 4; l++) begin
         if (be[l]) begin
            mv[w*4+l] = 1'b1;
            mb[(w*4+l)*8 +: 8] = d[l*8 +: 8];
         end
      end
      if (&mv) model_flush();
   endtask

   // monitor: every bus write against the model (R3, R4), hold and back-pressure (R8)
   always @(negedge clk) begin
      if (rst_n) begin
         if (held) begin
            chk(bus_valid && {bus_burst, bus_addr, bus_data, bus_be} == held_tr, "R8",
                "stalled write changed", {bus_burst, bus_addr, bus_be}, {held_tr.burst, held_tr.addr, held_tr.be});
            held = 1'b0;
         end
         if (bus_valid && st_valid)
            chk(!st_ready, "R8", "store accepted during drain", st_ready, 0);
         if (bus_valid && !bus_ready) begin
            held = 1'b1;
            held_tr = {bus_burst, bus_addr, bus_data, bus_be};
         end
         if (bus_valid && bus_ready) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R10", "unexpected bus write", bus_addr, 0);
            end else begin
               tr_t e;
               e = exp_q.pop_front();
               chk(bus_burst == e.burst && bus_addr == e.addr && bus_data == e.data && bus_be == e.be,
                   e.burst ? "R3" : "R4", "bus write", {bus_burst, bus_addr, bus_be, bus_data[31:0]},
                   {e.burst, e.addr, e.be, e.data[31:0]});
            end
         end
      end
   end

   task automatic do_store(input logic [31:0] a, input logic [3:0] be, input logic [31:0] d);
      bit miss;
      miss = (mv != '0) && (a[31:5] != mtag);
      if (miss) model_flush();
      @(negedge clk);
      st_valid = 1'b1; st_addr = a; st_be = be; st_data = d;
      #1;
      if (miss) chk(!st_ready, "R5", "store to other line not held", st_ready, 0);
      while (!st_ready) begin
         @(negedge clk); #1;
      end
      @(posedge clk);
      model_store(a, be, d);
      #1 st_valid = 1'b0;
   endtask

   task automatic do_acc(input logic [1:0] cls, input logic [31:0] a);
      if (cls == 2'd1 || cls == 2'd2 || (cls == 2'd3 && mv != '0 && a[31:5] != mtag))
         model_flush();
      @(negedge clk);
      acc_valid = 1'b1; acc_class = cls; acc_addr = a;
      @(posedge clk);
      #1 acc_valid = 1'b0;
   endtask

   task automatic do_ser;
      model_flush();
      @(negedge clk);
      ser_evt = 1'b1;
      @(posedge clk);
      #1 ser_evt = 1'b0;
   endtask

   task automatic expect_quiet(input string req, input string what);
      bit seen;
      seen = 1'b0;
      repeat (4) begin
         @(negedge clk);
         if (bus_valid) seen = 1'b1;
      end
      chk(!seen, req, what, seen, 0);
   endtask

   task automatic drain_all;
      int n;
      n = 0;
      while ((exp_q.size() != 0 || bus_valid) && n < 2000) begin
         @(negedge clk); n++;
      end
      @(negedge clk);
   endtask

   initial begin
      void'($urandom(32'd20250));
      mv = '0; mb = '0; mtag = '0; held = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R9: reset state
      chk(!bus_valid && st_ready, "R9", "reset state", {bus_valid, st_ready}, 2'b01);

      // R1: partial stores merge quietly; low address bits ignored
      do_store(32'h0000_1003, 4'b0011, 32'hAABB_CCDD);
      do_store(32'h0000_1014, 4'b1111, 32'h1122_3344);
      expect_quiet("R1", "partial line made bus traffic");
      // R2: overwrite byte 0 in place
      do_store(32'h0000_1000, 4'b0001, 32'h0000_00EE);
      expect_quiet("R2", "overwrite caused flush");
      // R6: cached access and write-combining load hit do nothing
      do_acc(2'd0, 32'h0000_9000);
      expect_quiet("R6", "cached access caused flush");
      do_acc(2'd3, 32'h0000_1010);
      expect_quiet("R6", "load hit caused flush");
      // R5: store to another line drains the old one first
      do_store(32'h0000_2040, 4'b0100, 32'h0055_0000);
      drain_all();
      // R3: complete the line, in descending order, with rewrites
      for (int w = 7; w >= 0; w--)
         do_store(32'h0000_2040 + 32'(w*4), 4'hF, 32'hC0DE_0000 + 32'(w));
      drain_all();
      // R10: triggers on an empty buffer
      do_ser;
      do_acc(2'd1, 32'h0);
      expect_quiet("R10", "flush of empty buffer");
      // R6 / R7: each flush class with a stalled bus (R8)
      do_store(32'h0000_3008, 4'b1001, 32'h1234_5678);
      rdy_force_low = 1'b1;
      do_acc(2'd1, 32'h0000_3000);
      repeat (3) @(negedge clk);
      rdy_force_low = 1'b0;
      drain_all();
      do_store(32'h0000_3018, 4'b0110, 32'h8765_4321);
      do_acc(2'd2, 32'h0000_0010);
      drain_all();
      do_store(32'h0000_3000, 4'b1111, 32'hDEAD_BEEF);
      do_acc(2'd3, 32'h0000_7000);
      drain_all();
      do_store(32'h0000_301C, 4'b1000, 32'h9900_0000);
      do_ser;  // R7
      drain_all();

      // random phase
      for (int i = 0; i < 1500; i++) begin
         int r;
         logic [31:0] base;
         r = $urandom % 20;
         base = 32'h0000_4000 + 32'(($urandom % 3) * 32);
         if (r < 14) do_store(base + 32'($urandom % 32), 4'(($urandom % 15) + 1), $urandom);
         else if (r == 14) do_acc(2'd0, $urandom);
         else if (r == 15) do_acc(2'd1, $urandom);
         else if (r == 16) do_acc(2'd2, $urandom);
         else if (r == 17) do_acc(2'd3, base);
         else if (r == 18) begin
            for (int w = 0; w < 8; w++) do_store(base + 32'(w*4), 4'hF, $urandom);
         end else do_ser;
      end
      do_ser;
      drain_all();
      chk(exp_q.size() == 0, "R4", "writes missing at end", exp_q.size(), 0);
      finish_run();
   end
endmodule